// File: doc/BRIEF.md
# Rotate Unit with Carry

This block performs bit rotations on 8-, 16- or 32-bit operands for an integer execution pipeline. Four operations are offered: a plain left rotation, a plain right rotation, and a left or right rotation in which the carry flag becomes one extra bit of the ring. The caller presents the operand, a size code, a rotate count, an operation code and the current carry flag, and pulses `start`. One clock later the rotated value, the new carry flag, the overflow flag and an indication of whether the overflow flag holds a defined value appear together with `valid`.

The count is reduced to its five low bits. A reduced count of zero leaves the value and every flag as they were. The overflow flag is only computed for a count of exactly one. For any other count the block keeps the overflow value it last produced and lowers `ov_defined`. Zero, sign, parity and half-carry flags are never produced here, so the caller keeps its own copies of them through any rotate.

Top module: `rot_carry_unit`

## Requirements
- R1: `valid` is high in the cycle after a cycle with `start` high and low otherwise. `result`, `carry_out`, `ov_out` and `ov_defined` change only at the clock edge where `start` is high and hold their values while `start` is low.
- R2: Operation code 0 rotates left. Each step moves the top bit of the operand into bit 0, and `carry_out` equals bit 0 of the result.
- R3: Operation code 1 rotates right. Each step moves bit 0 into the top bit of the operand, and `carry_out` equals the top bit of the result.
- R4: Operation code 2 rotates left through carry. Each step moves the old carry into bit 0 and the outgoing top bit into carry, so the count acts modulo width+1.
- R5: Operation code 3 rotates right through carry. Each step moves the old carry into the top bit and bit 0 into carry.
- R6: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the selected width are ignored, and the result is zero above that width.
- R7: Only the five low bits of the 8-bit count are used. A plain rotate by a count at or above the width wraps around the operand.
- R8: When the five low count bits are zero, `result` equals the sized operand, `carry_out` equals `carry_in`, `ov_out` keeps its value and `ov_defined` is low.
- R9: When the five low count bits equal one, `ov_out` is high exactly when the top bit of the result differs from the top bit of the sized operand, and `ov_defined` is high.
- R10: When the five low count bits are two or more, `ov_out` keeps its previous value and `ov_defined` is low.
- R11: A through-carry rotation by width+1 returns the original operand and the original carry.
- R12: After reset, `valid`, `result`, `carry_out`, `ov_out` and `ov_defined` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a rotation this cycle |
| operand | input | 32 | Value to rotate, low bits used for narrow sizes |
| size_sel | input | 2 | Operand width code (0: 8, 1: 16, 2 or 3: 32) |
| count | input | 8 | Rotate count, five low bits used |
| op_sel | input | 2 | 0 left, 1 right, 2 left through carry, 3 right through carry |
| carry_in | input | 1 | Current carry flag |
| valid | output | 1 | Result registered from the previous cycle's request |
| result | output | 32 | Rotated value, zero above the selected width |
| carry_out | output | 1 | New carry flag |
| ov_out | output | 1 | Overflow flag, updated only for a count of one |
| ov_defined | output | 1 | High when the last request had a count of one |

## Verification
The overflow register and the result/carry registers are updated under different conditions, yet both are written in the same clock edge. A count-of-one request followed at once by a multi-bit request makes a new result and carry land in the same cycle in which overflow must keep the value it just took. Back-to-back requests with mixed counts, sizes and operations are issued without idle cycles between them. A behavioural model that rotates one bit per loop pass judges every output on every clock.

// File: rtl/rot_pkg.sv
package rot_pkg;

  typedef enum logic [1:0] {
    ROT_L  = 2'd0,
    ROT_R  = 2'd1,
    ROT_LC = 2'd2,
    ROT_RC = 2'd3
  } rot_op_e;

  function automatic logic rot_is_left(input rot_op_e op);
    return (op == ROT_L) || (op == ROT_LC);
  endfunction

  function automatic logic rot_uses_carry(input rot_op_e op);
    return (op == ROT_LC) || (op == ROT_RC);
  endfunction

endpackage

// File: rtl/rot_lane.sv
module rot_lane
  import rot_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     val,
  input  logic             cin,
  input  rot_op_e          op,
  input  logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     res,
  output logic             cout
);

  localparam int RING_W = W + 1;

  int unsigned        plain_k;
  int unsigned        ring_k;
  logic [RING_W-1:0]  ring_in;
  logic [RING_W-1:0]  ring_out;
  logic [W-1:0]       plain_out;

  function automatic logic [W-1:0] rot_plain(input logic [W-1:0] v,
                                             input int unsigned k,
                                             input logic left);
    if (left) return (v << k) | (v >> (W - k));
    else      return (v >> k) | (v << (W - k));
  endfunction

  function automatic logic [RING_W-1:0] rot_ring(input logic [RING_W-1:0] v,
                                                 input int unsigned k,
                                                 input logic left);
    if (left) return (v << k) | (v >> (RING_W - k));
    else      return (v >> k) | (v << (RING_W - k));
  endfunction

  assign plain_k   = 32'(cnt) % W;
  assign ring_k    = 32'(cnt) % RING_W;
  assign ring_in   = {cin, val};
  assign plain_out = rot_plain(val, plain_k, rot_is_left(op));
  assign ring_out  = rot_ring(ring_in, ring_k, rot_is_left(op));

  always_comb begin
    res  = plain_out;
    cout = 1'b0;
    case (op)
      ROT_L:  cout = plain_out[0];
      ROT_R:  cout = plain_out[W-1];
      ROT_LC, ROT_RC: begin
        res  = ring_out[W-1:0];
        cout = ring_out[W];
      end
      default: cout = 1'b0;
    endcase
  end

endmodule

// File: rtl/rot_ovf_eval.sv
module rot_ovf_eval
  import rot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SZ_W   = 2
) (
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  input  logic [SZ_W-1:0]   sz_idx,
  input  rot_op_e           op,
  output logic              ov
);

  function automatic logic ov_single(input logic [DATA_W-1:0] r,
                                     input logic c,
                                     input int unsigned msb,
                                     input logic left);
    if (left) return r[msb] ^ c;
    else      return r[msb] ^ r[msb-1];
  endfunction

  int unsigned msb_pos;

  assign msb_pos = (32'd8 << sz_idx) - 32'd1;
  assign ov      = ov_single(res, cout, msb_pos, rot_is_left(op));

endmodule

// File: rtl/rot_carry_unit.sv
module rot_carry_unit
  import rot_pkg::*;
#(
  parameter int NUM_SIZES = 3,
  parameter int CNT_IN_W  = 8,
  parameter int CNT_W     = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [(8<<(NUM_SIZES-1))-1:0] operand,
  input  logic [1:0]                    size_sel,
  input  logic [CNT_IN_W-1:0]           count,
  input  logic [1:0]                    op_sel,
  input  logic                          carry_in,
  output logic                          valid,
  output logic [(8<<(NUM_SIZES-1))-1:0] result,
  output logic                          carry_out,
  output logic                          ov_out,
  output logic                          ov_defined
);

  localparam int DATA_W = 8 << (NUM_SIZES - 1);
  localparam int SZ_W   = 2;

  rot_op_e            op;
  logic [CNT_W-1:0]   cnt_eff;
  logic               cnt_is_zero;
  logic               cnt_is_one;
  logic [SZ_W-1:0]    sz_idx;

  logic [DATA_W-1:0]  lane_res [NUM_SIZES];
  logic [DATA_W-1:0]  lane_src [NUM_SIZES];
  logic [NUM_SIZES-1:0] lane_cf;

  logic [DATA_W-1:0]  rot_res;
  logic               rot_cf;
  logic [DATA_W-1:0]  sized_opd;
  logic [DATA_W-1:0]  nxt_res;
  logic               nxt_cf;
  logic               ov_calc;

  logic               valid_q;
  logic [DATA_W-1:0]  res_q;
  logic               cf_q;
  logic               of_q;
  logic               ovd_q;

  assign op          = rot_op_e'(op_sel);
  assign cnt_eff     = CNT_W'(count);
  assign cnt_is_zero = (cnt_eff == '0);
  assign cnt_is_one  = (cnt_eff == CNT_W'(1));
  assign sz_idx      = (32'(size_sel) >= NUM_SIZES) ? SZ_W'(NUM_SIZES - 1) : size_sel;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] lres;
    logic          lcf;

    rot_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
      .val  (operand[LW-1:0]),
      .cin  (carry_in),
      .op   (op),
      .cnt  (cnt_eff),
      .res  (lres),
      .cout (lcf)
    );

    assign lane_res[g] = DATA_W'(lres);
    assign lane_src[g] = DATA_W'(operand[LW-1:0]);
    assign lane_cf[g]  = lcf;
  end

  assign rot_res   = lane_res[sz_idx];
  assign rot_cf    = lane_cf[sz_idx];
  assign sized_opd = lane_src[sz_idx];

  rot_ovf_eval #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_ovf (
    .res    (rot_res),
    .cout   (rot_cf),
    .sz_idx (sz_idx),
    .op     (op),
    .ov     (ov_calc)
  );

  assign nxt_res = cnt_is_zero ? sized_opd : rot_res;
  assign nxt_cf  = cnt_is_zero ? carry_in  : rot_cf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      cf_q    <= 1'b0;
      of_q    <= 1'b0;
      ovd_q   <= 1'b0;
    end else begin
      valid_q <= start;
      if (start) begin
        res_q <= nxt_res;
        cf_q  <= nxt_cf;
        ovd_q <= cnt_is_one;
        if (cnt_is_one) of_q <= ov_calc;
      end
    end
  end

  assign valid      = valid_q;
  assign result     = res_q;
  assign carry_out  = cf_q;
  assign ov_out     = of_q;
  assign ov_defined = ovd_q;

endmodule

// File: rtl/rot_carry_unit_chk.sv
module rot_carry_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [DATA_W-1:0]   operand,
  input logic [1:0]          size_sel,
  input logic [CNT_IN_W-1:0] count,
  input logic [1:0]          op_sel,
  input logic                carry_in,
  input logic                valid,
  input logic [DATA_W-1:0]   result,
  input logic                carry_out,
  input logic                ov_out,
  input logic                ov_defined
);

  logic [CNT_W-1:0]  c5;
  logic [DATA_W-1:0] opd_sized;

  assign c5 = CNT_W'(count);
  assign opd_sized = (size_sel == 2'd0) ? (operand & DATA_W'(32'hFF)) :
                     (size_sel == 2'd1) ? (operand & DATA_W'(32'hFFFF)) : operand;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!valid && $stable(result) && $stable(carry_out) &&
                $stable(ov_out) && $stable(ov_defined)));

  assert_rol_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel == 2'd0 && c5 != '0) |=> (carry_out == result[0]));

  assert_ror_carry_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel == 2'd1 && size_sel[1] && c5 != '0) |=> (carry_out == result[DATA_W-1]));

  assert_narrow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && size_sel == 2'd0) |=> (result[DATA_W-1:8] == '0));

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && c5 == '0) |=> (result == $past(opd_sized) && carry_out == $past(carry_in) &&
                             $stable(ov_out) && !ov_defined));

  assert_single_defined_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && c5 == CNT_W'(1)) |=> ov_defined);

  assert_multi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && c5 > CNT_W'(1)) |=> ($stable(ov_out) && !ov_defined));

endmodule

bind rot_carry_unit rot_carry_unit_chk #(
  .DATA_W   (DATA_W),
  .CNT_IN_W (CNT_IN_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .operand    (operand),
  .size_sel   (size_sel),
  .count      (count),
  .op_sel     (op_sel),
  .carry_in   (carry_in),
  .valid      (valid),
  .result     (result),
  .carry_out  (carry_out),
  .ov_out     (ov_out),
  .ov_defined (ov_defined)
);

// File: tb/rot_carry_unit_test.sv
`timescale 1ns/1ps
module rot_carry_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] operand;
  logic [1:0]  size_sel;
  logic [7:0]  count;
  logic [1:0]  op_sel;
  logic        carry_in;
  logic        valid;
  logic [31:0] result;
  logic        carry_out;
  logic        ov_out;
  logic        ov_defined;

  always #2.5 clk = ~clk;

  rot_carry_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .size_sel(size_sel), .count(count), .op_sel(op_sel), .carry_in(carry_in),
    .valid(valid), .result(result), .carry_out(carry_out),
    .ov_out(ov_out), .ov_defined(ov_defined)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic        e_valid = 0;
  logic [31:0] e_res   = 0;
  logic        e_cf    = 0;
  logic        e_of    = 0;
  logic        e_ovd   = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string vtag, input string rtag, input string otag);
    chk(vtag, "valid",      32'(valid),      32'(e_valid));
    chk(rtag, "result",     result,          e_res);
    chk(rtag, "carry_out",  32'(carry_out),  32'(e_cf));
    chk(otag, "ov_out",     32'(ov_out),     32'(e_of));
    chk(otag, "ov_defined", 32'(ov_defined), 32'(e_ovd));
  endtask

  // Behavioural model: one bit per loop pass, applied at the coming edge.
  task automatic issue(input logic [31:0] opd, input logic [1:0] sz, input logic [7:0] cnt8,
                       input logic [1:0] op, input logic cin, input string tag);
    int w;
    int n;
    logic [31:0] mask;
    logic [31:0] v;
    logic c;
    logic b;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    v    = opd & mask;
    c    = cin;
    n    = int'(cnt8) % 32;
    for (int i = 0; i < n; i++) begin
      case (op)
        2'd0: begin c = v[w-1]; v = ((v << 1) | {31'b0, c}) & mask; end
        2'd1: begin c = v[0];   v = (v >> 1) | ({31'b0, c} << (w - 1)); end
        2'd2: begin b = v[w-1]; v = ((v << 1) | {31'b0, c}) & mask; c = b; end
        default: begin b = v[0]; v = (v >> 1) | ({31'b0, c} << (w - 1)); c = b; end
      endcase
    end
    if (n == 1) begin
      e_of  = v[w-1] ^ opd[w-1];
      e_ovd = 1'b1;
    end else begin
      e_ovd = 1'b0;
    end
    e_res   = v;
    e_cf    = c;
    e_valid = 1'b1;
    operand  = opd;
    size_sel = sz;
    count    = cnt8;
    op_sel   = op;
    carry_in = cin;
    start    = 1'b1;
    @(negedge clk);
    compare_all("R1", (n == 0) ? "R8" : tag,
                (n == 0) ? "R8" : (n == 1) ? "R9" : "R10");
  endtask

  task automatic idle(input logic [31:0] junk);
    start    = 1'b0;
    operand  = junk;
    count    = junk[7:0];
    carry_in = junk[8];
    e_valid  = 1'b0;
    @(negedge clk);
    compare_all("R1", "R1", "R1");
  endtask

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(200000.0 * 5.0);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r11_val;
    logic        r11_cf;
    rst_n = 1'b0; start = 1'b0; operand = '0; size_sel = '0;
    count = '0; op_sel = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R12", "R12", "R12");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R12", "R12", "R12");

    // R2 to R5 single steps on 8 bits, overflow defined (R9)
    issue(32'h0000_0081, 2'd0, 8'd1, 2'd0, 1'b0, "R2");
    issue(32'h0000_0081, 2'd0, 8'd1, 2'd1, 1'b0, "R3");
    issue(32'h0000_0081, 2'd0, 8'd1, 2'd2, 1'b0, "R4");
    issue(32'h0000_0040, 2'd0, 8'd1, 2'd3, 1'b1, "R5");
    // count one then multi-bit in consecutive cycles: overflow held (R10)
    issue(32'h0000_4000, 2'd1, 8'd1, 2'd0, 1'b0, "R9");
    issue(32'h0000_1234, 2'd1, 8'd5, 2'd1, 1'b1, "R10");
    idle(32'hDEAD_BEEF);
    idle(32'h1357_9BDF);
    // size handling and ignored upper operand bits (R6)
    issue(32'hABCD_EF5A, 2'd0, 8'd3, 2'd0, 1'b0, "R6");
    issue(32'hABCD_EF5A, 2'd1, 8'd4, 2'd1, 1'b0, "R6");
    issue(32'h8000_0001, 2'd3, 8'd1, 2'd1, 1'b0, "R6");
    // count masking and wrap (R7)
    issue(32'h0000_00C3, 2'd0, 8'hE1, 2'd0, 1'b0, "R7");
    issue(32'h0000_00C3, 2'd0, 8'h28, 2'd0, 1'b1, "R7");
    issue(32'h0000_8001, 2'd1, 8'd20, 2'd1, 1'b0, "R7");
    // zero count keeps flags (R8)
    issue(32'hFFFF_0000, 2'd2, 8'd1, 2'd2, 1'b1, "R9");
    issue(32'h1234_5678, 2'd0, 8'h60, 2'd3, 1'b1, "R8");
    issue(32'h1234_5678, 2'd2, 8'd0, 2'd0, 1'b0, "R8");
    // width+1 through-carry restores (R11)
    issue(32'h0000_00A5, 2'd0, 8'd9,  2'd2, 1'b1, "R11");
    chk("R11", "restore8", result, 32'h0000_00A5);
    chk("R11", "carry8",   32'(carry_out), 32'd1);
    issue(32'h0000_5A3C, 2'd1, 8'd17, 2'd3, 1'b0, "R11");
    chk("R11", "restore16", result, 32'h0000_5A3C);
    r11_val = 32'h0000_0096; r11_cf = 1'b0;
    for (int i = 0; i < 9; i++) begin
      issue(r11_val, 2'd0, 8'd1, 2'd2, r11_cf, "R11");
      r11_val = result;
      r11_cf  = carry_out;
    end
    chk("R11", "chain8", r11_val, 32'h0000_0096);
    chk("R11", "chaincf", 32'(r11_cf), 32'd0);
    // 32-bit through-carry ring
    issue(32'hC000_0003, 2'd2, 8'd31, 2'd2, 1'b1, "R4");
    issue(32'hC000_0003, 2'd2, 8'd31, 2'd3, 1'b0, "R5");

    // mixed traffic, back to back with occasional idles
    for (int k = 0; k < 600; k++) begin
      logic [31:0] rv;
      logic [1:0]  rop;
      rv  = $urandom;
      rop = rv[1:0];
      if (rv[31:29] == 3'd0) idle($urandom);
      else issue($urandom, rv[3:2], (rv[4] ? 8'(rv[12:5]) : 8'(rv[6:5])), rop, rv[13], op_tag(rop));
    end
    idle(32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule